// File: doc/BRIEF.md
# Heartbeat Window Watchdog

This block supervises a microcontroller by watching a heartbeat line for rising edges. An internal triangular oscillator is represented by a single phase flag that flips each time the half-period tick input pulses. One full oscillator period is one charge half followed by one discharge half. A period counter advances each time a charge half completes. Each clean rising heartbeat edge returns the counter to zero. If the processor stays silent for a whole window of periods, the block pulls its active-low fault output down. The fault is then held for a fixed number of further periods, however the heartbeat behaves in that time.

A heartbeat edge that arrives while the oscillator is charging also forces the oscillator into its discharge half, which keeps it aligned with the processor. When the enable input is low, the counter sits at zero, the oscillator is parked in its discharged state and no fault is shown. A request to disable that arrives during a fault is not acted upon until the fault has run its course. The counter value and the oscillator phase are brought out so that they can be observed.

Top module: `wdw_monitor`

## Requirements
- R1: While reset is held, and on its release, fault_n is 1, cnt_dbg is 0 and phase_chg is 0.
- R2: While enabled, cnt_dbg increases by one on each half_tick pulse that is taken while phase_chg is 1 (the end of a charge half), and it changes in no other way except by returning to 0.
- R3: While enabled, each half_tick pulse inverts phase_chg (1 means charging, 0 means discharging).
- R4: Outside a fault, a rising edge on hb_in returns cnt_dbg to 0. The edge passes through a two-stage synchronizer, so it takes effect on the third rising clock edge after hb_in is first sampled high.
- R5: When cnt_dbg reaches 48 (WIN_PERIODS) with no heartbeat edge, fault_n goes to 0 in that same cycle, and never earlier.
- R6: During a fault the counter keeps advancing once per period through 49 to 63. The period that would take it past 63 instead returns it to 0 and sets fault_n back to 1, giving 16 (LOW_PERIODS) periods of fault.
- R7: While fault_n is 0, heartbeat edges change neither cnt_dbg nor phase_chg.
- R8: A heartbeat edge that is taken while phase_chg is 1 sets phase_chg to 0. An edge taken while phase_chg is 0 leaves it at 0.
- R9: With wd_en low outside a fault, the block becomes inactive one clock later. From the clock after that, cnt_dbg is 0, phase_chg is 0 and fault_n is 1, and half_tick pulses and heartbeat edges have no effect.
- R10: If wd_en is low while fault_n is 0, the fault and the counting continue until the fault ends. Only after that is wd_en sampled and the block disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hb_in | input | 1 | Heartbeat from the supervised processor, asynchronous |
| wd_en | input | 1 | Watchdog enable, high to supervise |
| half_tick | input | 1 | One-cycle pulse at each oscillator half-period boundary |
| fault_n | output | 1 | Watchdog fault, active low |
| cnt_dbg | output | CNT_W (6) | Current period-counter value |
| phase_chg | output | 1 | Oscillator phase, 1 = charging, 0 = discharging |

## Verification
The assertions assume that half_tick is a single-cycle pulse separated by idle cycles. They also assume that wd_en changes only when the block is quiet, and that a heartbeat edge never falls in the same cycle as a tick. Under those conditions the counter either steps by one or clears, and the phase moves only on a tick or a resync. The stimulus keeps to this: every tick is one clock wide and followed by a clock without a tick, and each heartbeat pulse is held high for three clocks and low for three clocks with no ticks during it. wd_en is changed only between these operations, followed by two idle clocks before anything is checked.

// File: rtl/wdw_pkg.sv
// Shared definitions for the heartbeat window watchdog.
// Assumes: nothing beyond standard SystemVerilog.
package wdw_pkg;

    // Oscillator half: charging ramps up, discharging ramps down / parks at zero.
    typedef enum logic {
        PH_DISCHARGE = 1'b0,
        PH_CHARGE    = 1'b1
    } osc_phase_e;

    // Width of a counter that must hold window plus low-time periods.
    function automatic int cnt_width(input int win, input int low);
        return $clog2(win + low);
    endfunction

endpackage

// File: rtl/wdw_hb_sync.sv
// Heartbeat synchronizer and rising-edge detector.
// Brings the asynchronous heartbeat through STAGES flops, then flags a
// one-cycle pulse when the synchronized level goes from 0 to 1.
// Assumes: STAGES >= 2; heartbeat pulses are wider than STAGES+1 clocks.
module wdw_hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_in,
    output logic hb_rise
);

    logic [STAGES-1:0] sync_q;
    logic              level_q;

    // Build the synchronizer chain, one flop per stage.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw heartbeat.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= hb_in;
            end
        end else begin : g_next
            // Later stages pass the level along.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= sync_q[STAGES-1];
    end

    assign hb_rise = sync_q[STAGES-1] & ~level_q;

endmodule

// File: rtl/wdw_osc.sv
// Phase model of the triangular timing oscillator.
// The phase flips on every half-period tick. A heartbeat edge seen in the
// charge half forces the discharge half (resynchronization). Resync is
// suppressed during a fault. When inactive the phase parks at discharge.
// Assumes: half_tick is a single-cycle pulse.
module wdw_osc
    import wdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       in_fault,
    input  logic       hb_rise,
    input  logic       half_tick,
    output osc_phase_e phase
);

    logic resync;

    assign resync = hb_rise & ~in_fault & (phase == PH_CHARGE);

    // Advance, resynchronize or park the oscillator phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DISCHARGE;
        end else if (!active) begin
            phase <= PH_DISCHARGE;
        end else if (resync) begin
            phase <= PH_DISCHARGE;
        end else if (half_tick) begin
            phase <= (phase == PH_CHARGE) ? PH_DISCHARGE : PH_CHARGE;
        end
    end

endmodule

// File: rtl/wdw_core.sv
// Period counter, fault generation and deferred enable.
// Counts completed charge halves. A heartbeat edge clears the count outside
// a fault. Reaching WIN_PERIODS raises the fault, which lasts LOW_PERIODS
// further periods and then wraps the counter to zero. The enable is sampled
// only when no fault is active or being raised.
// Assumes: WIN_PERIODS >= 2, LOW_PERIODS >= 1.
module wdw_core
    import wdw_pkg::*;
#(
    parameter int WIN_PERIODS = 48,
    parameter int LOW_PERIODS = 16,
    localparam int CNT_W = cnt_width(WIN_PERIODS, LOW_PERIODS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_en,
    input  logic             hb_rise,
    input  logic             half_tick,
    input  osc_phase_e       phase,
    output logic             active,
    output logic             in_fault,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] PRE_FAULT = CNT_W'(WIN_PERIODS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WIN_PERIODS + LOW_PERIODS - 1);

    logic period_end;
    logic fault_set;
    logic fault_clr;

    assign period_end = active & half_tick & (phase == PH_CHARGE);
    assign fault_set  = ~in_fault & period_end & ~hb_rise & (cnt == PRE_FAULT);
    assign fault_clr  = in_fault & period_end & (cnt == LAST_CNT);

    // Sample the enable only when no fault is running or starting.
    always_ff @(posedge clk) begin
        if (!rst_n)                       active <= 1'b0;
        else if (!in_fault && !fault_set) active <= wd_en;
    end

    // Track the fault low time.
    always_ff @(posedge clk) begin
        if (!rst_n)         in_fault <= 1'b0;
        else if (!active)   in_fault <= 1'b0;
        else if (fault_set) in_fault <= 1'b1;
        else if (fault_clr) in_fault <= 1'b0;
    end

    // Count oscillator periods, clear on heartbeat, wrap after the low time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (in_fault) begin
            if (fault_clr)       cnt <= '0;
            else if (period_end) cnt <= cnt + 1'b1;
        end else if (hb_rise) begin
            cnt <= '0;
        end else if (period_end) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdw_monitor.sv
// Heartbeat window watchdog, top level.
// Joins the heartbeat synchronizer, the oscillator phase model and the
// period counter. The fault is brought out active low. Counter and phase are
// exposed for observation.
// Assumes: half_tick is produced by the oscillator timing source in this
// clock domain as one-cycle pulses.
module wdw_monitor
    import wdw_pkg::*;
#(
    parameter int WIN_PERIODS = 48,
    parameter int LOW_PERIODS = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = cnt_width(WIN_PERIODS, LOW_PERIODS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_in,
    input  logic             wd_en,
    input  logic             half_tick,
    output logic             fault_n,
    output logic [CNT_W-1:0] cnt_dbg,
    output logic             phase_chg
);

    logic       hb_rise;
    logic       wd_active;
    logic       in_fault;
    osc_phase_e phase;

    wdw_hb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .hb_in   (hb_in),
        .hb_rise (hb_rise)
    );

    wdw_osc u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (wd_active),
        .in_fault  (in_fault),
        .hb_rise   (hb_rise),
        .half_tick (half_tick),
        .phase     (phase)
    );

    wdw_core #(
        .WIN_PERIODS (WIN_PERIODS),
        .LOW_PERIODS (LOW_PERIODS)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_en     (wd_en),
        .hb_rise   (hb_rise),
        .half_tick (half_tick),
        .phase     (phase),
        .active    (wd_active),
        .in_fault  (in_fault),
        .cnt       (cnt_dbg)
    );

    assign fault_n   = ~in_fault;
    assign phase_chg = (phase == PH_CHARGE);

endmodule

// File: rtl/wdw_monitor_chk.sv
// Property checker for the heartbeat window watchdog, bound to the top.
// Assumes: half_tick pulses are one cycle wide.
module wdw_monitor_chk
    import wdw_pkg::*;
#(
    parameter int WIN_PERIODS = 48,
    parameter int LOW_PERIODS = 16,
    localparam int CNT_W = cnt_width(WIN_PERIODS, LOW_PERIODS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             half_tick,
    input logic             fault_n,
    input logic [CNT_W-1:0] cnt_dbg,
    input logic             phase_chg,
    input logic             wd_active
);

    localparam logic [CNT_W-1:0] WIN_C  = CNT_W'(WIN_PERIODS);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WIN_PERIODS + LOW_PERIODS - 1);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_dbg) |-> (cnt_dbg == $past(cnt_dbg) + 1'b1) || (cnt_dbg == '0));

    p_phase_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_chg) |-> $past(half_tick));

    p_fault_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> cnt_dbg == WIN_C);

    p_fault_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> (cnt_dbg == '0) && ($past(cnt_dbg) == LAST_C));

    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && !half_tick) |=> $stable(cnt_dbg) && $stable(phase_chg));

    p_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_active |=> (cnt_dbg == '0) && !phase_chg && fault_n);

    p_enable_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |=> $stable(wd_active));

endmodule

bind wdw_monitor wdw_monitor_chk #(
    .WIN_PERIODS (WIN_PERIODS),
    .LOW_PERIODS (LOW_PERIODS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .fault_n   (fault_n),
    .cnt_dbg   (cnt_dbg),
    .phase_chg (phase_chg),
    .wd_active (wd_active)
);

// File: tb/test_wdw_monitor.sv
`timescale 1ns/1ps
module test_wdw_monitor;

    localparam int WIN  = 48;
    localparam int LOW  = 16;
    localparam int CW   = $clog2(WIN + LOW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hb_in = 1'b0;
    logic          wd_en = 1'b0;
    logic          half_tick = 1'b0;
    logic          fault_n;
    logic [CW-1:0] cnt_dbg;
    logic          phase_chg;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    wdw_monitor #(
        .WIN_PERIODS (WIN),
        .LOW_PERIODS (LOW),
        .SYNC_STAGES (2)
    ) i_wdw_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .hb_in     (hb_in),
        .wd_en     (wd_en),
        .half_tick (half_tick),
        .fault_n   (fault_n),
        .cnt_dbg   (cnt_dbg),
        .phase_chg (phase_chg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all three observable outputs against expectations.
    task automatic chk_state(input int ec, input int ep, input int ef, input string req);
        chk(int'(cnt_dbg) == ec, {req, " count"}, int'(cnt_dbg), ec);
        chk(int'(phase_chg) == ep, {req, " phase"}, int'(phase_chg), ep);
        chk(int'(fault_n) == ef, {req, " fault_n"}, int'(fault_n), ef);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle half-period tick, followed by a quiet cycle boundary.
    task automatic tick();
        @(negedge clk) half_tick = 1'b1;
        @(negedge clk) half_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Heartbeat pulse: high three clocks (edge acted on at the third), low three.
    task automatic hb_pulse();
        @(negedge clk) hb_in = 1'b1;
        idle(3);
        hb_in = 1'b0;
        idle(3);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog all requirements: got %0d expected %0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        idle(4);
        chk_state(0, 0, 1, "R1 during reset");
        rst_n = 1'b1;
        idle(1);
        chk_state(0, 0, 1, "R1 after reset");

        // R9: disabled from reset, ticks and heartbeat do nothing
        ticks(3);
        hb_pulse();
        chk_state(0, 0, 1, "R9 idle disabled");

        // R2 R3 R5: full window sweep with no heartbeat
        wd_en = 1'b1;
        idle(2);
        for (int n = 1; n <= 2 * WIN; n++) begin
            tick();
            chk(int'(phase_chg) == n % 2, "R3 phase toggle", int'(phase_chg), n % 2);
            chk(int'(cnt_dbg) == n / 2, "R2 period count", int'(cnt_dbg), n / 2);
            chk(int'(fault_n) == ((n < 2 * WIN) ? 1 : 0), "R5 fault at window",
                int'(fault_n), (n < 2 * WIN) ? 1 : 0);
        end

        // R7: heartbeat during fault in both phases
        hb_pulse();
        chk_state(WIN, 0, 0, "R7 edge in fault discharge");
        tick();
        hb_pulse();
        chk_state(WIN, 1, 0, "R7 edge in fault charge");

        // R6: low time runs 16 periods, then wraps and releases
        for (int n = 2 * WIN + 2; n <= 2 * (WIN + LOW); n++) begin
            tick();
            chk(int'(cnt_dbg) == (n / 2) % (WIN + LOW), "R6 low-time count",
                int'(cnt_dbg), (n / 2) % (WIN + LOW));
            chk(int'(fault_n) == ((n < 2 * (WIN + LOW)) ? 0 : 1), "R6 low-time fault",
                int'(fault_n), (n < 2 * (WIN + LOW)) ? 0 : 1);
        end
        chk_state(0, 0, 1, "R6 released");

        // R4: heartbeat clears every count in the window
        for (int m = 1; m < WIN; m++) begin
            ticks(2 * m);
            chk(int'(cnt_dbg) == m, "R4 before clear", int'(cnt_dbg), m);
            hb_pulse();
            chk_state(0, 0, 1, "R4 cleared");
        end

        // R8: edge in discharge keeps the phase, edge in charge forces discharge
        ticks(6);
        hb_pulse();
        chk_state(0, 0, 1, "R8 discharge edge");
        tick();
        chk_state(0, 1, 1, "R8 charging");
        hb_pulse();
        chk_state(0, 0, 1, "R8 charge edge resync");
        tick();
        chk_state(0, 1, 1, "R8 after resync tick1");
        tick();
        chk_state(1, 0, 1, "R8 after resync tick2");

        // R9: disable mid-window while charging parks everything
        hb_pulse();
        ticks(21);
        chk_state(10, 1, 1, "R9 before disable");
        wd_en = 1'b0;
        idle(2);
        chk_state(0, 0, 1, "R9 parked");
        ticks(3);
        hb_pulse();
        chk_state(0, 0, 1, "R9 ignores inputs");

        // R10: disable during fault is deferred until the low time ends
        wd_en = 1'b1;
        idle(2);
        ticks(2 * WIN);
        chk_state(WIN, 0, 0, "R10 fault reached");
        wd_en = 1'b0;
        idle(3);
        chk_state(WIN, 0, 0, "R10 fault held");
        ticks(2);
        chk_state(WIN + 1, 0, 0, "R10 still counting");
        ticks(2 * LOW - 2);
        chk_state(0, 0, 1, "R10 released");
        idle(2);
        tick();
        chk_state(0, 0, 1, "R10 now disabled");

        summary();
        $finish;
    end

endmodule